// File: doc/BRIEF.md
# Coprocessor Start-Address Checker

This block decides whether a coprocessor may begin fetching instructions at a given program bank and 16-bit program counter. The host presents the bank, the PC, the program-cache state and the mode register, then pulses a request strobe. The block replies on the next cycle with a verdict, a fault code, and a packed 32-bit address word that can be reported when the start is refused.

The block is checked once per launch. The first question is whether the PC lies inside the active program-cache window. If it does not, the memory map decides: some banks are unmapped holes, some are work RAM that the coprocessor may only use when it owns RAM, and the rest are ROM, which it may only use when it owns ROM. Each check also produces a step-over target. This is the PC advanced past the instruction whose opcode sits in the fetch pipe, so that a debugger can place a stop address after the current instruction.

Top module: `start_addr_check`

## Requirements
- R1: When `cache_on` is 1 and `cache_base <= pc < cache_base + 512`, the start is valid. The sum is taken in 17 bits and does not wrap. This rule takes precedence over every memory-map rule.
- R2: With no cache hit, a bank below 0x40 with a PC below 0x8000 is refused with fault code 1 (map hole).
- R3: With no cache hit, banks 0x60 to 0x6F and banks 0x74 to 0xFF are refused with fault code 1 (map hole).
- R4: With no cache hit, banks 0x70 to 0x73 are valid only if `mode` bit 3 (RAM owned) is 1. Otherwise the start is refused with fault code 2.
- R5: With no cache hit, every other bank is valid only if `mode` bit 4 (ROM owned) is 1. Otherwise the start is refused with fault code 3.
- R6: On refusal, `illegal_addr` equals `{bank, 8'h00, pc}`. On a valid start it is 0, and the fault code is 0.
- R7: `step_point` is the PC advanced modulo 2^16 by:
  - 2 for pipe opcodes 0x05 to 0x0F and 0xA0 to 0xAF;
  - 3 for 0xF0 to 0xFF;
  - 1 for all other opcodes.
- R8: All outputs update on the clock edge at which `chk_req` is sampled high. They hold their values in every cycle without a request.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_req | input | 1 | Check request strobe |
| bank | input | 8 | Program bank of the start address |
| pc | input | 16 | Program counter of the start address |
| cache_on | input | 1 | Program cache holds valid code |
| cache_base | input | 16 | First address of the cache window |
| mode | input | 8 | Mode register; bit 3 RAM owned, bit 4 ROM owned |
| pipe_op | input | 8 | Opcode currently in the fetch pipe |
| start_ok | output | 1 | Start address is allowed |
| fault | output | 2 | 0 ok, 1 map hole, 2 RAM not owned, 3 ROM not owned |
| illegal_addr | output | 32 | Packed refused address, 0 when allowed |
| step_point | output | 16 | Step-over target address |

## Verification
Several properties are checked on every cycle:
- outputs hold between requests;
- every cache hit yields a valid start;
- the RAM and hole banks are refused when they should be;
- the refusal word repacks the sampled bank and PC;
- the step distance is always 1, 2 or 3.

Only the bench scenarios can show the exact precedence between rules, such as a cache hit that rescues a hole bank. They also cover:
- the inclusive and exclusive edges of the cache window, including a window that runs past 0xFFFF;
- the exact opcode class boundaries;
- PC wrap in the step target;
- the reset values.

// File: rtl/start_chk_pkg.sv
package start_chk_pkg;
    localparam int BANK_W = 8;
    localparam int PC_W   = 16;
    localparam int MODE_W = 8;
    localparam int OP_W   = 8;
    localparam int GAP_W  = 8;
    localparam int ILL_W  = BANK_W + GAP_W + PC_W;

    typedef enum logic [1:0] {
        FLT_OK      = 2'd0,
        FLT_HOLE    = 2'd1,
        FLT_RAM_OFF = 2'd2,
        FLT_ROM_OFF = 2'd3
    } fault_e;

    typedef struct packed {
        logic               ok;
        fault_e             fault;
        logic [ILL_W-1:0]   ill;
        logic [PC_W-1:0]    step;
    } result_t;
endpackage

// File: rtl/start_cache_window.sv
module start_cache_window
    import start_chk_pkg::*;
#(
    parameter int CACHE_BYTES = 512
) (
    input  logic            cache_on,
    input  logic [PC_W-1:0] cache_base,
    input  logic [PC_W-1:0] pc,
    output logic            hit
);
    localparam int SUM_W = PC_W + 1;
    logic [SUM_W-1:0] top_excl;
    always_comb begin
        top_excl = {1'b0, cache_base} + SUM_W'(CACHE_BYTES);
        hit      = cache_on && (pc >= cache_base) && ({1'b0, pc} < top_excl);
    end
endmodule

// File: rtl/start_map_class.sv
module start_map_class
    import start_chk_pkg::*;
#(
    parameter int RAM_OWN_BIT = 3,
    parameter int ROM_OWN_BIT = 4,
    parameter logic [BANK_W-1:0] LOW_BANK_LIM = 8'h40,
    parameter logic [PC_W-1:0]   LOW_PC_LIM   = 16'h8000,
    parameter logic [BANK_W-1:0] GAP_LO       = 8'h60,
    parameter logic [BANK_W-1:0] GAP_HI       = 8'h6F,
    parameter logic [BANK_W-1:0] RAM_LO       = 8'h70,
    parameter logic [BANK_W-1:0] RAM_HI       = 8'h73
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [PC_W-1:0]   pc,
    input  logic [MODE_W-1:0] mode,
    output fault_e            fault
);
    logic low_hole, gap_hole, high_hole, is_ram;
    always_comb begin
        low_hole  = (bank < LOW_BANK_LIM) && (pc < LOW_PC_LIM);
        gap_hole  = (bank >= GAP_LO) && (bank <= GAP_HI);
        high_hole = (bank > RAM_HI);
        is_ram    = (bank >= RAM_LO) && (bank <= RAM_HI);
        if (low_hole || gap_hole || high_hole)
            fault = FLT_HOLE;
        else if (is_ram)
            fault = mode[RAM_OWN_BIT] ? FLT_OK : FLT_RAM_OFF;
        else
            fault = mode[ROM_OWN_BIT] ? FLT_OK : FLT_ROM_OFF;
    end
endmodule

// File: rtl/start_step_calc.sv
module start_step_calc
    import start_chk_pkg::*;
(
    input  logic [PC_W-1:0] pc,
    input  logic [OP_W-1:0] op,
    output logic [PC_W-1:0] step
);
    logic [1:0] len;
    always_comb begin
        if (op >= 8'hF0)
            len = 2'd3;
        else if ((op >= 8'h05 && op <= 8'h0F) || (op >= 8'hA0 && op <= 8'hAF))
            len = 2'd2;
        else
            len = 2'd1;
        step = pc + PC_W'(len);
    end
endmodule

// File: rtl/start_addr_check.sv
module start_addr_check
    import start_chk_pkg::*;
#(
    parameter int CACHE_BYTES = 512,
    parameter int RAM_OWN_BIT = 3,
    parameter int ROM_OWN_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_req,
    input  logic [BANK_W-1:0] bank,
    input  logic [PC_W-1:0]   pc,
    input  logic              cache_on,
    input  logic [PC_W-1:0]   cache_base,
    input  logic [MODE_W-1:0] mode,
    input  logic [OP_W-1:0]   pipe_op,
    output logic              start_ok,
    output logic [1:0]        fault,
    output logic [ILL_W-1:0]  illegal_addr,
    output logic [PC_W-1:0]   step_point
);
    logic      cache_hit;
    fault_e    map_fault;
    logic [PC_W-1:0] step_nxt;
    result_t   res_d, res_q;

    start_cache_window #(.CACHE_BYTES(CACHE_BYTES)) u_win (
        .cache_on(cache_on), .cache_base(cache_base), .pc(pc), .hit(cache_hit)
    );

    start_map_class #(.RAM_OWN_BIT(RAM_OWN_BIT), .ROM_OWN_BIT(ROM_OWN_BIT)) u_map (
        .bank(bank), .pc(pc), .mode(mode), .fault(map_fault)
    );

    start_step_calc u_step (.pc(pc), .op(pipe_op), .step(step_nxt));

    always_comb begin
        res_d = res_q;
        if (chk_req) begin
            res_d.fault = cache_hit ? FLT_OK : map_fault;
            res_d.ok    = (res_d.fault == FLT_OK);
            res_d.ill   = res_d.ok ? '0 : {bank, GAP_W'(0), pc};
            res_d.step  = step_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign start_ok     = res_q.ok;
    assign fault        = res_q.fault;
    assign illegal_addr = res_q.ill;
    assign step_point   = res_q.step;

    // R1
    cache_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req && cache_hit |=> start_ok);

    // R3
    gap_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req && !cache_hit && bank >= 8'h60 && bank <= 8'h6F |=> fault == FLT_HOLE);

    // R4
    ram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req && !cache_hit && bank >= 8'h70 && bank <= 8'h73 && !mode[RAM_OWN_BIT]
        |=> !start_ok && fault == FLT_RAM_OFF);

    // R6
    packed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |=> (start_ok ? (illegal_addr == '0)
                              : (illegal_addr == {$past(bank), GAP_W'(0), $past(pc)})));

    // R7
    step_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |=> (PC_W'(step_point - $past(pc)) >= 16'd1) &&
                    (PC_W'(step_point - $past(pc)) <= 16'd3));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_req |=> $stable(start_ok) && $stable(fault) &&
                     $stable(illegal_addr) && $stable(step_point));
endmodule

// File: tb/tb_start_addr_check.sv
`timescale 1ns/1ps
module tb_start_addr_check;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        chk_req = 0;
    logic [7:0]  bank = 0;
    logic [15:0] pc = 0;
    logic        cache_on = 0;
    logic [15:0] cache_base = 0;
    logic [7:0]  mode = 0;
    logic [7:0]  pipe_op = 0;
    logic        start_ok;
    logic [1:0]  fault;
    logic [31:0] illegal_addr;
    logic [15:0] step_point;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    start_addr_check dut (
        .clk(clk), .rst_n(rst_n), .chk_req(chk_req), .bank(bank), .pc(pc),
        .cache_on(cache_on), .cache_base(cache_base), .mode(mode), .pipe_op(pipe_op),
        .start_ok(start_ok), .fault(fault), .illegal_addr(illegal_addr), .step_point(step_point)
    );

    typedef struct packed {
        logic [7:0]  bk;
        logic [15:0] p;
        logic        con;
        logic [15:0] cb;
        logic [7:0]  md;
        logic [7:0]  op;
        logic        ev;
        logic [1:0]  ef;
        logic [15:0] est;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 16'h1000, 1'b1, 16'h0F00, 8'h00, 8'h01, 1'b1, 2'd0, 16'h1001}, // R1 hit over hole
        '{8'h00, 16'h1000, 1'b0, 16'h0F00, 8'h00, 8'h01, 1'b0, 2'd1, 16'h1001}, // R2
        '{8'h00, 16'h8000, 1'b0, 16'h0000, 8'h10, 8'h05, 1'b1, 2'd0, 16'h8002}, // R5 R7
        '{8'h00, 16'h8000, 1'b0, 16'h0000, 8'h00, 8'h0F, 1'b0, 2'd3, 16'h8002}, // R5
        '{8'h65, 16'h9000, 1'b0, 16'h0000, 8'h18, 8'hA0, 1'b0, 2'd1, 16'h9002}, // R3
        '{8'h74, 16'hC000, 1'b0, 16'h0000, 8'h18, 8'hAF, 1'b0, 2'd1, 16'hC002}, // R3
        '{8'h70, 16'h0000, 1'b0, 16'h0000, 8'h08, 8'hF0, 1'b1, 2'd0, 16'h0003}, // R4 R7
        '{8'h73, 16'h1234, 1'b0, 16'h0000, 8'h10, 8'hFF, 1'b0, 2'd2, 16'h1237}, // R4
        '{8'h40, 16'h0100, 1'b0, 16'h0000, 8'h10, 8'h04, 1'b1, 2'd0, 16'h0101}, // R2 edge
        '{8'h3F, 16'h7FFF, 1'b0, 16'h0000, 8'h10, 8'hB0, 1'b0, 2'd1, 16'h8000}, // R2 edge
        '{8'h5F, 16'hFFFF, 1'b0, 16'h0000, 8'h10, 8'hF5, 1'b1, 2'd0, 16'h0002}, // R7 wrap
        '{8'h60, 16'h10FF, 1'b1, 16'h0F00, 8'h00, 8'h00, 1'b1, 2'd0, 16'h1100}, // R1 last byte
        '{8'h60, 16'h1100, 1'b1, 16'h0F00, 8'h00, 8'h00, 1'b0, 2'd1, 16'h1101}, // R1 past end
        '{8'h6F, 16'h0EFF, 1'b1, 16'h0F00, 8'h00, 8'h00, 1'b0, 2'd1, 16'h0F00}, // R1 below base
        '{8'h74, 16'hFFFF, 1'b1, 16'hFF00, 8'h00, 8'h00, 1'b1, 2'd0, 16'h0000}, // R1 17-bit top
        '{8'h74, 16'h0000, 1'b1, 16'hFF00, 8'h00, 8'h00, 1'b0, 2'd1, 16'h0001}, // R1 no wrap
        '{8'h72, 16'h2000, 1'b0, 16'h0000, 8'h08, 8'h50, 1'b1, 2'd0, 16'h2001}, // R4
        '{8'h71, 16'h3000, 1'b0, 16'h0000, 8'h08, 8'h10, 1'b1, 2'd0, 16'h3001}  // R7 class edge
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        bank = v.bk; pc = v.p; cache_on = v.con; cache_base = v.cb;
        mode = v.md; pipe_op = v.op; chk_req = 1;
        @(negedge clk);
        chk_req = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        chk_req = 1; bank = 8'h70; mode = 8'h18;
        repeat (3) @(negedge clk);
        // R9 outputs zero in reset, even with a request pending
        check("R9 ok", {31'd0, start_ok}, 32'd0);
        check("R9 fault", {30'd0, fault}, 32'd0);
        check("R9 ill", illegal_addr, 32'd0);
        check("R9 step", {16'd0, step_point}, 32'd0);
        chk_req = 0;
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check("R1-5 ok", {31'd0, start_ok}, {31'd0, VEC[i].ev});
            check("R2 R3 R4 R5 fault", {30'd0, fault}, {30'd0, VEC[i].ef});
            check("R6 ill", illegal_addr,
                  VEC[i].ev ? 32'd0 : {VEC[i].bk, 8'h00, VEC[i].p});
            check("R7 step", {16'd0, step_point}, {16'd0, VEC[i].est});
        end

        // R8 hold: inputs change without request, outputs keep last result
        apply('{8'h65, 16'hABCD, 1'b0, 16'h0000, 8'h00, 8'hF1, 1'b0, 2'd1, 16'hABD0});
        bank = 8'h50; pc = 16'h9000; mode = 8'h10; pipe_op = 8'h00;
        repeat (3) @(negedge clk);
        check("R8 hold ok", {31'd0, start_ok}, 32'd0);
        check("R8 hold fault", {30'd0, fault}, 32'd1);
        check("R8 hold ill", illegal_addr, 32'h6500ABCD);
        check("R8 hold step", {16'd0, step_point}, 32'h0000ABD0);

        // R8 one-cycle latency: result present right after the request edge
        @(negedge clk); chk_req = 1;
        @(negedge clk); chk_req = 0;
        check("R8 latency ok", {31'd0, start_ok}, 32'd1);
        check("R8 latency step", {16'd0, step_point}, 32'h00009001);

        // R9 reset after activity
        rst_n = 0;
        @(negedge clk);
        check("R9 reclear ok", {31'd0, start_ok}, 32'd0);
        check("R9 reclear step", {16'd0, step_point}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule